// File: doc/BRIEF.md
# Instruction/Data Split Address Translator

This block sits between the segment mapper of a small processor's memory unit and the bank-select decode. Each access arrives as a 20-bit segment-mapped address. It comes with a tag that says which logical segment produced it (root, data segment or other) and a tag for the kind of access (instruction fetch, data read or data write). The translator may flip physical bit 16, physical bit 19, or both. This moves the access by 64K or 512K before the bank decision is made. The result is registered and goes on to bank selection.

An 8-bit configuration register controls the flips. Each segment has its own pair of enables. A mode bit limits the flips to data reads and writes. With that bit set, instruction fetches from the root and data segments stay where they are, while data traffic to the same logical addresses lands in a different physical region. This gives separate instruction and data spaces. One more bit holds chip select 1 active at all times, and the block presents it as an output. The translator keeps no state from one access to the next. A block move that issues a long run of back-to-back data reads and writes therefore gets the same translation on every iteration.

Top module: `isplit_addr_xlat`

## Requirements
- R1: After reset the configuration reads back 0x00, `phys_valid` is 0, `phys_addr` is 0 and `cs1_force` is 0.
- R2: For an access tagged root (`acc_seg`=01), config bit 0 flips address bit 16 and config bit 1 flips address bit 19. All other address bits always pass unchanged.
- R3: For an access tagged data segment (`acc_seg`=10), config bit 2 flips address bit 16 and config bit 3 flips address bit 19. The root enables (bits 1:0) have no effect on these accesses, and the data-segment enables (bits 3:2) have no effect on root accesses.
- R4: With config bit 5 clear, the flips apply to every access kind, including instruction fetch (`acc_kind`=00).
- R5: With config bit 5 set, an instruction fetch leaves the address unchanged. Data reads (01), data writes (10) and kind code 11 are still flipped.
- R6: Accesses tagged other (00) or the spare tag (11) pass through unflipped, whatever the configuration.
- R7: `cs1_force` equals config bit 4 from the cycle after the write that set it.
- R8: A write to the configuration stores bits 5:0. Bits 7:6 are discarded and read back as zero. The written value is visible on `cfg_rd_data` one cycle after the write.
- R9: `phys_addr` and `phys_valid` update one clock after an access with `acc_valid`=1. When `acc_valid` is 0, `phys_valid` goes to 0 the next cycle and `phys_addr` holds its value.
- R10: A burst of back-to-back data accesses (a block move alternating source reads and destination writes) is translated correctly on every cycle of the burst, not only the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write value |
| cfg_rd_data | output | 8 | Configuration read value, bits 7:6 always zero |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 20 | Segment-mapped address before flipping |
| acc_seg | input | 2 | Segment tag: 00 other, 01 root, 10 data segment, 11 spare |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 data read, 10 data write, 11 treated as data |
| phys_valid | output | 1 | Registered copy of acc_valid |
| phys_addr | output | 20 | Translated address to bank selection |
| cs1_force | output | 1 | Hold chip select 1 active |

## Verification
A corrupted configuration bit is visible on `cfg_rd_data` one cycle after the write. It also shows on the next translated address of the matching segment, as bit 16 or bit 19 wrong on `phys_addr` one clock after the access. A fault in the fetch/data qualification shows up only as a pair: a fetch and a data access to the same address with the split mode on must come out different, and they must come out equal with it off. A translation that carried state between accesses would show up within the second cycle of a back-to-back burst. For that reason the bench checks every cycle of a block-move-like sequence.

// File: rtl/isplit_pkg.sv
package isplit_pkg;

  typedef enum logic [1:0] {
    SEG_OTHER = 2'b00,
    SEG_ROOT  = 2'b01,
    SEG_DATA  = 2'b10,
    SEG_SPARE = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_RD    = 2'b01,
    ACC_WR    = 2'b10,
    ACC_OTHER = 2'b11
  } kind_e;

  // Bit positions are software-visible and therefore fixed.
  typedef struct packed {
    logic [1:0] spare;      // 7:6
    logic       data_only;  // 5
    logic       cs1_hold;   // 4
    logic       dseg_hi;    // 3
    logic       dseg_lo;    // 2
    logic       root_hi;    // 1
    logic       root_lo;    // 0
  } split_cfg_t;

endpackage

// File: rtl/isplit_cfg_reg.sv
module isplit_cfg_reg
  import isplit_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int KEEP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);

  localparam int ZERO_W = CFG_W - KEEP_W;

  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = {{ZERO_W{1'b0}}, wr_data[KEEP_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  // R8: a write lands in the low bits on the next cycle, the top bits stay clear
  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[KEEP_W-1:0] == $past(wr_data[KEEP_W-1:0])) &&
              (cfg_q[CFG_W-1:KEEP_W] == '0));

  // R8: without a write the register holds
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/isplit_flip_decode.sv
module isplit_flip_decode
  import isplit_pkg::*;
(
  input  split_cfg_t cfg,
  input  seg_e       seg,
  input  kind_e      kind,
  output logic       flip_lo,
  output logic       flip_hi
);

  logic is_data;
  logic qualify;

  always_comb begin
    is_data = (kind != ACC_FETCH);
    qualify = !cfg.data_only || is_data;
    flip_lo = 1'b0;
    flip_hi = 1'b0;
    if (qualify) begin
      unique case (seg)
        SEG_ROOT: begin
          flip_lo = cfg.root_lo;
          flip_hi = cfg.root_hi;
        end
        SEG_DATA: begin
          flip_lo = cfg.dseg_lo;
          flip_hi = cfg.dseg_hi;
        end
        default: begin
          flip_lo = 1'b0;
          flip_hi = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/isplit_addr_xlat.sv
module isplit_addr_xlat
  import isplit_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LO_BIT  = 16,
  parameter int HI_BIT  = 19,
  parameter int CFG_W   = 8,
  parameter int KEEP_W  = 6,
  parameter int CS1_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_seg,
  input  logic [1:0]        acc_kind,
  output logic              phys_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              cs1_force
);

  localparam logic [ADDR_W-1:0] KEEP_MASK =
    ~((ADDR_W'(1) << LO_BIT) | (ADDR_W'(1) << HI_BIT));

  logic [CFG_W-1:0]  cfg_q;
  split_cfg_t        cfg_s;
  logic              flip_lo;
  logic              flip_hi;
  logic [ADDR_W-1:0] flip_mask;
  logic [ADDR_W-1:0] xlat_d;
  logic [ADDR_W-1:0] addr_d;
  logic              valid_d;

  isplit_cfg_reg #(.CFG_W(CFG_W), .KEEP_W(KEEP_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_q)
  );

  assign cfg_s       = split_cfg_t'(cfg_q);
  assign cfg_rd_data = cfg_q;
  assign cs1_force   = cfg_q[CS1_BIT];

  isplit_flip_decode u_dec (
    .cfg     (cfg_s),
    .seg     (seg_e'(acc_seg)),
    .kind    (kind_e'(acc_kind)),
    .flip_lo (flip_lo),
    .flip_hi (flip_hi)
  );

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
    if (gi == HI_BIT) begin : g_hi
      assign flip_mask[gi] = flip_hi;
    end else if (gi == LO_BIT) begin : g_lo
      assign flip_mask[gi] = flip_lo;
    end else begin : g_pass
      assign flip_mask[gi] = 1'b0;
    end
  end

  assign xlat_d = acc_addr ^ flip_mask;

  always_comb begin
    valid_d = acc_valid;
    addr_d  = phys_addr;
    if (acc_valid) begin
      addr_d = xlat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_valid <= 1'b0;
      phys_addr  <= '0;
    end else begin
      phys_valid <= valid_d;
      if (acc_valid) begin
        phys_addr <= addr_d;
      end
    end
  end

  // R9: valid follows the request with one cycle of latency
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> phys_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !phys_valid);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(phys_addr));

  // R2: only the two selected bits may ever differ from the input
  p_other_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ((phys_addr ^ $past(acc_addr)) & KEEP_MASK) == '0);

  // R6: accesses outside root and data segment are never moved
  p_outside_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_seg == SEG_OTHER || acc_seg == SEG_SPARE))
    |=> phys_addr == $past(acc_addr));

  // R5: in split mode fetches keep their address
  p_fetch_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == ACC_FETCH && cfg_q[5])
    |=> phys_addr == $past(acc_addr));

  // R7: chip-select hold tracks the written bit
  p_cs1_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cs1_force == $past(cfg_wr_data[CS1_BIT]));

endmodule

// File: tb/isplit_addr_xlat_tb.sv
module isplit_addr_xlat_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic        acc_valid;
  logic [19:0] acc_addr;
  logic [1:0]  acc_seg;
  logic [1:0]  acc_kind;
  logic        phys_valid;
  logic [19:0] phys_addr;
  logic        cs1_force;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  isplit_addr_xlat u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .acc_seg     (acc_seg),
    .acc_kind    (acc_kind),
    .phys_valid  (phys_valid),
    .phys_addr   (phys_addr),
    .cs1_force   (cs1_force)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {cfg, seg, kind, addr, expected}; seg 00 other 01 root 10 data 11 spare;
  // kind 00 fetch 01 read 10 write 11 other
  localparam int NV = 17;
  localparam logic [51:0] VEC [NV] = '{
    {8'h01, 2'b01, 2'b00, 20'h12345, 20'h02345}, // R2 R4 root lo on fetch
    {8'h02, 2'b01, 2'b01, 20'h12345, 20'h92345}, // R2 root hi
    {8'h03, 2'b01, 2'b10, 20'h12345, 20'h82345}, // R2 both
    {8'h04, 2'b10, 2'b01, 20'h12345, 20'h02345}, // R3 dseg lo
    {8'h08, 2'b10, 2'b10, 20'h12345, 20'h92345}, // R3 dseg hi
    {8'h0C, 2'b10, 2'b00, 20'h12345, 20'h82345}, // R4 fetch flipped
    {8'h2F, 2'b10, 2'b00, 20'h12345, 20'h12345}, // R5 fetch clean
    {8'h2F, 2'b01, 2'b00, 20'h12345, 20'h12345}, // R5 fetch clean root
    {8'hEF, 2'b10, 2'b01, 20'h12345, 20'h82345}, // R5 R8 read flipped
    {8'hDF, 2'b01, 2'b10, 20'h12345, 20'h82345}, // R7 R8
    {8'h0F, 2'b00, 2'b01, 20'h12345, 20'h12345}, // R6 other
    {8'h03, 2'b10, 2'b01, 20'h12345, 20'h12345}, // R3 root bits ignored
    {8'h0C, 2'b01, 2'b01, 20'h12345, 20'h12345}, // R3 dseg bits ignored
    {8'h0F, 2'b11, 2'b01, 20'h12345, 20'h12345}, // R6 spare tag
    {8'h2F, 2'b10, 2'b11, 20'h12345, 20'h82345}, // R5 kind 11 is data
    {8'h0F, 2'b01, 2'b01, 20'hF0ABC, 20'h60ABC}, // R2 clears set bits
    {8'h01, 2'b10, 2'b01, 20'hF0ABC, 20'hF0ABC}  // R3
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_wr_data = '0;
    acc_valid = 1'b0;
    acc_addr = '0;
    acc_seg = '0;
    acc_kind = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg", 32'(cfg_rd_data), 32'h00);
    check("R1 valid", 32'(phys_valid), 32'h0);
    check("R1 addr", 32'(phys_addr), 32'h0);
    check("R1 cs1", 32'(cs1_force), 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][51:44]);
      check("R8 readback", 32'(cfg_rd_data), 32'(VEC[i][51:44] & 8'h3F));
      check("R7 cs1", 32'(cs1_force), 32'(VEC[i][48]));
      acc_valid = 1'b1;
      acc_seg   = VEC[i][43:42];
      acc_kind  = VEC[i][41:40];
      acc_addr  = VEC[i][39:20];
      @(posedge clk);
      @(negedge clk);
      acc_valid = 1'b0;
      check($sformatf("R2-6 vec%0d", i), 32'(phys_addr), 32'(VEC[i][19:0]));
      check("R9 valid", 32'(phys_valid), 32'h1);
    end

    // R9: idle cycle holds the address and drops valid
    acc_addr = 20'hFFFFF;
    @(negedge clk);
    check("R9 drop", 32'(phys_valid), 32'h0);
    check("R9 hold", 32'(phys_addr), 32'hF0ABC);

    // R10: back-to-back block move, split mode, all four flips enabled
    write_cfg(8'h2F);
    for (int k = 0; k < 8; k++) begin
      logic [19:0] a;
      a = 20'h10000 + 20'(k * 20'h111);
      acc_valid = 1'b1;
      acc_seg   = (k % 2 == 0) ? 2'b10 : 2'b01;
      acc_kind  = (k % 2 == 0) ? 2'b01 : 2'b10;
      acc_addr  = a;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R10 iter%0d", k), 32'(phys_addr), 32'(a ^ 20'h90000));
      check("R10 valid", 32'(phys_valid), 32'h1);
    end
    // R5 fetch inside the burst stays clean
    acc_seg  = 2'b10;
    acc_kind = 2'b00;
    acc_addr = 20'h0BEEF;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R5 burst fetch", 32'(phys_addr), 32'h0BEEF);

    // R1: reset in the middle clears everything again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg after reset", 32'(cfg_rd_data), 32'h00);
    check("R1 cs1 after reset", 32'(cs1_force), 32'h0);
    check("R1 addr after reset", 32'(phys_addr), 32'h0);

    // R1: reset configuration performs no flip
    acc_valid = 1'b1;
    acc_seg   = 2'b01;
    acc_kind  = 2'b01;
    acc_addr  = 20'h9ABCD;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R1 no flip", 32'(phys_addr), 32'h9ABCD);

    finish_run();
  end

endmodule